// File: doc/BRIEF.md
# Device Capability Array Walker

This block discovers where a device's register blocks live. After reset, or when software pulses `start`, it walks a capability array in memory through a simple 32-bit read port. The array begins with a header that carries an identifying value and a count of entries. Each entry names one capability and gives the byte offset of that capability's register block. For each entry the walker decodes the capability identifier. It then records the absolute base address of the device-status block, the primary mailbox block and the memory-device block. It also notes a secondary mailbox if one appears.

When the walk ends, the block raises a one-cycle `done`. At the same time it gives a verdict. The verdict is success, a header mismatch (no device), or a mask of the required blocks that were not found. The recorded bases and the verdict hold until the next walk. Mapping the blocks and accessing their contents belong to other logic.

Top module: `cap_array_walker`

## Requirements
- R1: Once reset is released, a walk starts with no `start` pulse. `busy` is high in the first cycle after release, and the first read is issued at `array_base`.
- R2: A `start` pulse while idle begins a new walk, which first clears every recorded base and found flag to zero. A `start` pulse while `busy` is high is ignored, and the walk in progress continues its read sequence unchanged.
- R3: Each read holds `rd_req` high with `rd_addr` stable until `rd_valid` is seen. The word on `rd_data` is taken in the cycle where `rd_req` and `rd_valid` are both high.
- R4: The header identifier is bits [15:0] of the word at `array_base`. If it differs from `ARRAY_ID`, the walk stops after that single read. The result is then `err_nodev`=1, `ok`=0, `err_missing`=0 and `missing_mask`=3'b111.
- R5: The entry count is bits [15:0] of the word at `array_base`+4. Entries are visited for n = 1 up to and including the count. Entry n is read first at `array_base`+16·n and then at `array_base`+16·n+4. A walk therefore makes 2+2·count reads, and a count of zero makes no entry reads.
- R6: The capability identifier is bits [15:0] of an entry's first word, and the upper 16 bits are ignored. The identifier 0x0001 sets `stat_base`, 0x0002 sets `mbox_base` and 0x4000 sets `mdev_base`. Each recorded base equals `array_base` plus the entry's 32-bit offset word.
- R7: The identifier 0x0003 sets `sec_found` and `sec_base`, but it never counts as a required block. Entries with any other identifier are skipped without error.
- R8: If an identifier appears in more than one entry, the base from the later entry replaces the earlier one.
- R9: At the end of a walk, `done` pulses for one cycle with `busy` low. `ok`=1 only when all three required blocks were found. Otherwise `err_missing`=1 and `missing_mask` flags each absent block: bit 0 for status, bit 1 for primary mailbox and bit 2 for memory device.
- R10: While idle, the verdict and the recorded bases hold their values, and no read is issued until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a new walk while idle |
| array_base | input | AW | Byte address of the capability array header |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | AW | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| ok | output | 1 | All three required blocks found |
| err_nodev | output | 1 | Header identifier mismatch |
| err_missing | output | 1 | At least one required block absent |
| missing_mask | output | 3 | Absent blocks: bit0 status, bit1 primary mailbox, bit2 memory device |
| stat_base | output | AW | Device-status block base |
| mbox_base | output | AW | Primary mailbox block base |
| mdev_base | output | AW | Memory-device block base |
| sec_found | output | 1 | Secondary mailbox entry seen |
| sec_base | output | AW | Secondary mailbox block base |

## Verification
The bench builds the walker with a 32-bit address and a 16-bit count field. It overrides `ARRAY_ID` to 0x00A5, so an all-zero bus return cannot pass the header check, and a header of 0x00A4 exercises the no-device path. Placing the array at 0x20000 with non-zero offsets makes every recorded base depend on both the base input and the offset word. Read latencies of zero to two wait cycles, counts from zero to six, and plausible-looking entries placed just past the counted range bring off-by-one overruns, early exits, duplicate identifiers and handshake stalls within reach.

// File: rtl/capw_pkg.sv
// Shared types and constants for the capability array walker.
// Assumes entries are 16-byte strided and that words are 4 bytes.
package capw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BOOT,
        S_HDR_ID,
        S_HDR_CNT,
        S_ENT_ID,
        S_ENT_OFF,
        S_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        PH_HDR_ID,
        PH_HDR_CNT,
        PH_ENT_ID,
        PH_ENT_OFF
    } rd_phase_t;

    localparam int CAPID_W    = 16;
    localparam int NUM_REQ    = 3;
    localparam int STRIDE_LG2 = 4;
    localparam int WORD_LG2   = 2;

    localparam int SLOT_STAT  = 0;
    localparam int SLOT_PMB   = 1;
    localparam int SLOT_MDEV  = 2;

endpackage

// File: rtl/capw_addr.sv
// Read address generator.
// Forms the byte address of the word named by the current read phase and entry index.
// Assumes CNT_W + STRIDE_LG2 fits in AW.
module capw_addr
    import capw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic [AW-1:0]    array_base,
    input  rd_phase_t        phase,
    input  logic [CNT_W-1:0] idx,
    output logic [AW-1:0]    rd_addr
);

    localparam int OFS_W = CNT_W + STRIDE_LG2;

    logic [CNT_W-1:0] ent_idx;
    logic             second_word;
    logic [OFS_W-1:0] ofs;

    // Select the entry number (0 for the header) and which word inside it.
    always_comb begin
        ent_idx     = '0;
        second_word = 1'b0;
        case (phase)
            PH_HDR_ID:  begin ent_idx = '0;  second_word = 1'b0; end
            PH_HDR_CNT: begin ent_idx = '0;  second_word = 1'b1; end
            PH_ENT_ID:  begin ent_idx = idx; second_word = 1'b0; end
            PH_ENT_OFF: begin ent_idx = idx; second_word = 1'b1; end
            default:    begin ent_idx = '0;  second_word = 1'b0; end
        endcase
    end

    // Combine the stride offset with the word offset and add the base.
    always_comb begin
        ofs     = {ent_idx, {STRIDE_LG2{1'b0}}} | OFS_W'({second_word, {WORD_LG2{1'b0}}});
        rd_addr = array_base + AW'(ofs);
    end

endmodule

// File: rtl/capw_seq.sv
// Walk sequencer.
// Steps through header id, header count, then id/offset word pairs for entries 1..count.
// Assumes CNT_W <= 16 and that the count field occupies bits [CNT_W-1:0] of the count word.
// The reset state launches a walk, so one begins as soon as reset is released.
module capw_seq
    import capw_pkg::*;
#(
    parameter int                 CNT_W    = 16,
    parameter logic [CAPID_W-1:0] ARRAY_ID = 16'h0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rd_valid,
    input  logic [CAPID_W-1:0] rd_lo,
    output logic               rd_req,
    output rd_phase_t          phase,
    output logic [CNT_W-1:0]   idx,
    output logic               busy,
    output logic               clr,
    output logic               id_cap,
    output logic               off_cap,
    output logic               fin,
    output logic               nodev
);

    walk_state_t      state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] idx_q;
    logic             nodev_q;
    logic             acc;
    logic             last_ent;

    assign acc      = rd_req & rd_valid;
    assign last_ent = (idx_q == count_q);

    // Decode read request and capture strobes from the state.
    always_comb begin
        rd_req  = (state_q == S_HDR_ID) || (state_q == S_HDR_CNT) ||
                  (state_q == S_ENT_ID) || (state_q == S_ENT_OFF);
        busy    = (state_q != S_IDLE);
        clr     = (state_q == S_BOOT);
        fin     = (state_q == S_DONE);
        id_cap  = acc && (state_q == S_ENT_ID);
        off_cap = acc && (state_q == S_ENT_OFF);
        idx     = idx_q;
        nodev   = nodev_q;
        case (state_q)
            S_HDR_CNT: phase = PH_HDR_CNT;
            S_ENT_ID:  phase = PH_ENT_ID;
            S_ENT_OFF: phase = PH_ENT_OFF;
            default:   phase = PH_HDR_ID;
        endcase
    end

    // Choose the next state from the current one and the read handshake.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:    if (start) state_d = S_BOOT;
            S_BOOT:    state_d = S_HDR_ID;
            S_HDR_ID:  if (acc) state_d = (rd_lo == ARRAY_ID) ? S_HDR_CNT : S_DONE;
            S_HDR_CNT: if (acc) state_d = (rd_lo[CNT_W-1:0] == '0) ? S_DONE : S_ENT_ID;
            S_ENT_ID:  if (acc) state_d = S_ENT_OFF;
            S_ENT_OFF: if (acc) state_d = last_ent ? S_DONE : S_ENT_ID;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Register the state; reset lands in the launch state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    // Track the entry count, the current entry index and the header verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            idx_q   <= '0;
            nodev_q <= 1'b0;
        end else begin
            case (state_q)
                S_BOOT: begin
                    count_q <= '0;
                    idx_q   <= '0;
                    nodev_q <= 1'b0;
                end
                S_HDR_ID: if (acc && (rd_lo != ARRAY_ID)) nodev_q <= 1'b1;
                S_HDR_CNT: if (acc) begin
                    count_q <= rd_lo[CNT_W-1:0];
                    idx_q   <= CNT_W'(1);
                end
                S_ENT_OFF: if (acc && !last_ent) idx_q <= idx_q + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // A start pulse during a walk must not relaunch it.
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (state_q != S_BOOT));

    // Entry reads only address entries 1..count.
    p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_ENT_ID) || (state_q == S_ENT_OFF)) |->
            ((idx_q != '0) && (idx_q <= count_q)));

    // A header mismatch ends the walk right after the first read.
    p_nodev_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_HDR_ID) && acc && (rd_lo != ARRAY_ID)) |=> (state_q == S_DONE));

endmodule

// File: rtl/capw_capreg.sv
// Capture and verdict registers.
// Latches each entry's identifier, dispatches the following offset word to the matching
// base register, and forms the verdict when the walk finishes.
// Assumes the identifier word is always read before its offset word.
module capw_capreg
    import capw_pkg::*;
#(
    parameter int                 AW      = 32,
    parameter logic [CAPID_W-1:0] ID_STAT = 16'h0001,
    parameter logic [CAPID_W-1:0] ID_PMB  = 16'h0002,
    parameter logic [CAPID_W-1:0] ID_SMB  = 16'h0003,
    parameter logic [CAPID_W-1:0] ID_MDEV = 16'h4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               id_cap,
    input  logic               off_cap,
    input  logic               fin,
    input  logic               nodev,
    input  logic [31:0]        rd_data,
    input  logic [AW-1:0]      array_base,
    output logic [AW-1:0]      stat_base,
    output logic [AW-1:0]      mbox_base,
    output logic [AW-1:0]      mdev_base,
    output logic               sec_found,
    output logic [AW-1:0]      sec_base,
    output logic               done,
    output logic               ok,
    output logic               err_nodev,
    output logic               err_missing,
    output logic [NUM_REQ-1:0] missing_mask
);

    localparam logic [CAPID_W-1:0] REQ_ID [NUM_REQ] = '{ID_STAT, ID_PMB, ID_MDEV};

    logic [CAPID_W-1:0] ent_id_q;
    logic [AW-1:0]      new_base;
    logic [NUM_REQ-1:0] found;
    logic [AW-1:0]      base_w [NUM_REQ];
    logic               sec_q;
    logic [AW-1:0]      sec_base_q;

    assign new_base = array_base + AW'(rd_data);

    // Hold the identifier of the entry being read until its offset arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      ent_id_q <= '0;
        else if (clr)    ent_id_q <= '0;
        else if (id_cap) ent_id_q <= rd_data[CAPID_W-1:0];
    end

    // One base register and found flag for each required block.
    for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_slot
        logic [AW-1:0] q;
        logic          hit_q;

        // Record the base when an entry carries this slot's identifier; later entries win.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                q     <= '0;
                hit_q <= 1'b0;
            end else if (off_cap && (ent_id_q == REQ_ID[gi])) begin
                q     <= new_base;
                hit_q <= 1'b1;
            end
        end

        assign base_w[gi] = q;
        assign found[gi]  = hit_q;
    end

    // Record the secondary mailbox, which never counts as a required block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sec_q      <= 1'b0;
            sec_base_q <= '0;
        end else if (off_cap && (ent_id_q == ID_SMB)) begin
            sec_q      <= 1'b1;
            sec_base_q <= new_base;
        end
    end

    // Form the verdict and the end pulse when the sequencer finishes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            done         <= 1'b0;
            ok           <= 1'b0;
            err_nodev    <= 1'b0;
            err_missing  <= 1'b0;
            missing_mask <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                ok           <= !nodev && (&found);
                err_nodev    <= nodev;
                err_missing  <= !nodev && !(&found);
                missing_mask <= nodev ? {NUM_REQ{1'b1}} : ~found;
            end
        end
    end

    assign stat_base = base_w[SLOT_STAT];
    assign mbox_base = base_w[SLOT_PMB];
    assign mdev_base = base_w[SLOT_MDEV];
    assign sec_found = sec_q;
    assign sec_base  = sec_base_q;

    // Exactly one of success and the two error outcomes at the end pulse.
    p_verdict_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok != (err_nodev || err_missing)) && !(err_nodev && err_missing));

    // Success never reports a missing block.
    p_ok_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (missing_mask == '0));

    // Launching a walk wipes every recorded finding.
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (found == '0) && !sec_q && (stat_base == '0) && (mdev_base == '0));

endmodule

// File: rtl/cap_array_walker.sv
// Capability array walker, top level.
// Joins the sequencer, the address generator and the capture registers.
// Assumes array_base is held stable during a walk.
module cap_array_walker
    import capw_pkg::*;
#(
    parameter int                 AW       = 32,
    parameter int                 CNT_W    = 16,
    parameter logic [CAPID_W-1:0] ARRAY_ID = 16'h0000,
    parameter logic [CAPID_W-1:0] ID_STAT  = 16'h0001,
    parameter logic [CAPID_W-1:0] ID_PMB   = 16'h0002,
    parameter logic [CAPID_W-1:0] ID_SMB   = 16'h0003,
    parameter logic [CAPID_W-1:0] ID_MDEV  = 16'h4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [AW-1:0]      array_base,
    output logic               rd_req,
    output logic [AW-1:0]      rd_addr,
    input  logic               rd_valid,
    input  logic [31:0]        rd_data,
    output logic               busy,
    output logic               done,
    output logic               ok,
    output logic               err_nodev,
    output logic               err_missing,
    output logic [NUM_REQ-1:0] missing_mask,
    output logic [AW-1:0]      stat_base,
    output logic [AW-1:0]      mbox_base,
    output logic [AW-1:0]      mdev_base,
    output logic               sec_found,
    output logic [AW-1:0]      sec_base
);

    rd_phase_t        phase;
    logic [CNT_W-1:0] idx;
    logic             clr;
    logic             id_cap;
    logic             off_cap;
    logic             fin;
    logic             nodev;

    capw_seq #(
        .CNT_W    (CNT_W),
        .ARRAY_ID (ARRAY_ID)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_valid (rd_valid),
        .rd_lo    (rd_data[CAPID_W-1:0]),
        .rd_req   (rd_req),
        .phase    (phase),
        .idx      (idx),
        .busy     (busy),
        .clr      (clr),
        .id_cap   (id_cap),
        .off_cap  (off_cap),
        .fin      (fin),
        .nodev    (nodev)
    );

    capw_addr #(
        .AW    (AW),
        .CNT_W (CNT_W)
    ) u_addr (
        .array_base (array_base),
        .phase      (phase),
        .idx        (idx),
        .rd_addr    (rd_addr)
    );

    capw_capreg #(
        .AW      (AW),
        .ID_STAT (ID_STAT),
        .ID_PMB  (ID_PMB),
        .ID_SMB  (ID_SMB),
        .ID_MDEV (ID_MDEV)
    ) u_capreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .id_cap       (id_cap),
        .off_cap      (off_cap),
        .fin          (fin),
        .nodev        (nodev),
        .rd_data      (rd_data),
        .array_base   (array_base),
        .stat_base    (stat_base),
        .mbox_base    (mbox_base),
        .mdev_base    (mdev_base),
        .sec_found    (sec_found),
        .sec_base     (sec_base),
        .done         (done),
        .ok           (ok),
        .err_nodev    (err_nodev),
        .err_missing  (err_missing),
        .missing_mask (missing_mask)
    );

    // A pending read keeps its request and address until accepted.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // The end pulse arrives only once the walker has gone idle.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // While idle and not started, results hold and no read goes out.
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!rd_req && $stable(ok) && $stable(missing_mask) &&
                               $stable(stat_base) && $stable(mbox_base) && $stable(mdev_base)));

endmodule

// File: tb/cap_array_walker_bench.sv
// Self-checking bench for the capability array walker.
module cap_array_walker_bench;

    localparam int          AW   = 32;
    localparam logic [15:0] AID  = 16'h00A5;
    localparam logic [31:0] BASE = 32'h0002_0000;
    localparam int          NV   = 8;

    // Vector: {hdr_good, count[3:0], slot1..slot6 codes (3 bits each), expected missing mask}
    // Codes: 0 -> 0x0007, 1 -> 0x0001, 2 -> 0x0002, 3 -> 0x0003, 4 -> 0x4000, 5 -> 0xC001
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 4'd3, 3'd1, 3'd2, 3'd4, 3'd0, 3'd0, 3'd0, 3'b000},
        {1'b1, 4'd4, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0, 3'b000},
        {1'b1, 4'd2, 3'd1, 3'd2, 3'd4, 3'd4, 3'd4, 3'd4, 3'b100},
        {1'b1, 4'd0, 3'd1, 3'd2, 3'd4, 3'd1, 3'd2, 3'd4, 3'b111},
        {1'b0, 4'd3, 3'd1, 3'd2, 3'd4, 3'd0, 3'd0, 3'd0, 3'b111},
        {1'b1, 4'd6, 3'd5, 3'd1, 3'd0, 3'd2, 3'd4, 3'd3, 3'b000},
        {1'b1, 4'd4, 3'd1, 3'd2, 3'd4, 3'd1, 3'd0, 3'd0, 3'b000},
        {1'b1, 4'd3, 3'd3, 3'd5, 3'd0, 3'd1, 3'd2, 3'd4, 3'b111}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] array_base = BASE;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [31:0]   rd_data = '0;
    logic          busy, done, ok, err_nodev, err_missing, sec_found;
    logic [2:0]    missing_mask;
    logic [AW-1:0] stat_base, mbox_base, mdev_base, sec_base;

    int          nchk = 0;
    int          nfail = 0;
    int          nreads = 0;
    int          lat = 0;
    logic [25:0] cur_vec = VEC[0];

    always #10 clk = ~clk;

    cap_array_walker #(
        .AW       (AW),
        .CNT_W    (16),
        .ARRAY_ID (AID)
    ) u_cap_array_walker (
        .clk (clk), .rst_n (rst_n), .start (start), .array_base (array_base),
        .rd_req (rd_req), .rd_addr (rd_addr), .rd_valid (rd_valid), .rd_data (rd_data),
        .busy (busy), .done (done), .ok (ok), .err_nodev (err_nodev),
        .err_missing (err_missing), .missing_mask (missing_mask),
        .stat_base (stat_base), .mbox_base (mbox_base), .mdev_base (mdev_base),
        .sec_found (sec_found), .sec_base (sec_base)
    );

    function automatic logic [15:0] code_id(input logic [2:0] c);
        case (c)
            3'd1:    return 16'h0001;
            3'd2:    return 16'h0002;
            3'd3:    return 16'h0003;
            3'd4:    return 16'h4000;
            3'd5:    return 16'hC001;
            default: return 16'h0007;
        endcase
    endfunction

    function automatic logic [2:0] slot_code(input logic [25:0] v, input int n);
        if (n < 1 || n > 6) return 3'd0;
        return v[23-3*n -: 3];
    endfunction

    function automatic logic [31:0] off_of(input int n);
        return 32'h100 * n + 32'h40;
    endfunction

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        logic [31:0] rel;
        rel = a - BASE;
        if (rel == 32'h0) return {16'h5A5A, cur_vec[25] ? AID : (AID - 16'h1)};
        if (rel == 32'h4) return {16'hFFFF, 12'h000, cur_vec[24:21]};
        if (rel[3:2] == 2'd0) return {16'hBEEF, code_id(slot_code(cur_vec, int'(rel >> 4)))};
        if (rel[3:2] == 2'd1) return off_of(int'(rel >> 4));
        return 32'hDEAD_BEEF;
    endfunction

    function automatic logic [31:0] exp_addr(input int k);
        if (k == 0) return BASE;
        if (k == 1) return BASE + 32'h4;
        return BASE + 32'h10 * ((k - 2) / 2 + 1) + 32'h4 * ((k - 2) % 2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read responder: answers after lat wait cycles and checks the address order.
    initial begin
        int wcnt;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rd_valid = 1'b0;
                wcnt = 0;
            end else if (rd_valid) begin
                rd_valid = 1'b0;
                wcnt = 0;
            end else if (rd_req) begin
                if (wcnt >= lat) begin
                    chk((nreads == 0) ? "R1 first read address" : "R5 read address",
                        rd_addr, exp_addr(nreads));
                    rd_data  = mem_rd(rd_addr);
                    rd_valid = 1'b1;
                    nreads++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic wait_done();
        bit seen;
        seen = 1'b0;
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        chk("R9 done pulse seen", {31'd0, seen}, 32'd1);
    endtask

    task automatic check_results(input int v);
        logic          good;
        int            cnt;
        logic [2:0]    mask;
        logic [AW-1:0] eb [3];
        logic [AW-1:0] es;
        logic          esf;
        logic [15:0]   id;
        good = cur_vec[25];
        cnt  = int'(cur_vec[24:21]);
        mask = cur_vec[2:0];
        eb   = '{default: '0};
        es   = '0;
        esf  = 1'b0;
        if (good) begin
            for (int n = 1; n <= cnt; n++) begin
                id = code_id(slot_code(cur_vec, n));
                if (id == 16'h0001) eb[0] = BASE + off_of(n);
                if (id == 16'h0002) eb[1] = BASE + off_of(n);
                if (id == 16'h4000) eb[2] = BASE + off_of(n);
                if (id == 16'h0003) begin es = BASE + off_of(n); esf = 1'b1; end
            end
        end
        chk("R9 busy low at done", {31'd0, busy}, 32'd0);
        chk(good ? "R9 ok" : "R4 ok", {31'd0, ok}, {31'd0, good && (mask == 3'b000)});
        chk("R4 err_nodev", {31'd0, err_nodev}, {31'd0, !good});
        chk("R9 err_missing", {31'd0, err_missing}, {31'd0, good && (mask != 3'b000)});
        chk(good ? "R9 missing_mask" : "R4 missing_mask", {29'd0, missing_mask}, {29'd0, mask});
        chk(good ? "R5 read count" : "R4 read count", nreads, good ? 2 + 2 * cnt : 1);
        chk((v == 6) ? "R8 stat_base" : (eb[0] == '0 ? "R2 stat_base" : "R6 stat_base"),
            stat_base, eb[0]);
        chk(eb[1] == '0 ? "R2 mbox_base" : "R6 mbox_base", mbox_base, eb[1]);
        chk(eb[2] == '0 ? "R2 mdev_base" : "R6 mdev_base", mdev_base, eb[2]);
        chk("R7 sec_found", {31'd0, sec_found}, {31'd0, esf});
        chk("R7 sec_base", sec_base, es);
    endtask

    task automatic run_vec(input int v, input bit poke_mid);
        cur_vec = VEC[v];
        lat     = v % 3;
        nreads  = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_mid) begin
            repeat (5) @(negedge clk);
            chk("R2 still busy before mid-walk start", {31'd0, busy}, 32'd1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done();
        check_results(v);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic          h_ok;
        logic [2:0]    h_mask;
        logic [AW-1:0] h_stat;
        // Reset state.
        cur_vec = VEC[0];
        lat     = 0;
        nreads  = 0;
        repeat (3) @(negedge clk);
        chk("R1 no read in reset", {31'd0, rd_req}, 32'd0);
        chk("R1 no done in reset", {31'd0, done}, 32'd0);
        chk("R1 ok clear in reset", {31'd0, ok}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy right after reset", {31'd0, busy}, 32'd1);
        wait_done();
        check_results(0);

        // Table of vectors, walked by one loop.
        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

        // Start pulse during a walk is ignored.
        run_vec(5, 1'b1);

        // Results hold while idle and no read goes out.
        h_ok   = ok;
        h_mask = missing_mask;
        h_stat = stat_base;
        repeat (15) @(negedge clk);
        chk("R10 ok held", {31'd0, ok}, {31'd0, h_ok});
        chk("R10 mask held", {29'd0, missing_mask}, {29'd0, h_mask});
        chk("R10 stat_base held", stat_base, h_stat);
        chk("R10 no read while idle", {31'd0, rd_req}, 32'd0);
        chk("R10 no read count while idle", nreads, 14);

        // Recorded bases are cleared by a new walk that finds nothing required.
        run_vec(6, 1'b0);
        run_vec(7, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule